// File: doc/BRIEF.md
# Nested priority interrupt controller

This block gathers interrupt requests from four source classes (software-raised program faults, a timer, I/O completion and hardware failure) and hands the processor one request line plus a 2-bit source number. A request is latched as soon as it is seen, so the processor does not have to be listening at that moment. It may look only when an instruction finishes executing, and the request is still there. The processor answers with an acknowledge, which takes the presented source, and later with an end-of-service strobe when its handler is done.

A mode input chooses between two policies at run time. With nesting off, nothing new is offered while any service is active: requests wait until the service ends. With nesting on, a request whose priority is strictly above every active service is offered at once. The active services form a stack kept as one bit per source. Ending a service retires only the top entry, so a preempted lower-priority handler is still marked active and carries on.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset no source is pending or in service, `irq_req` is 0 and `irq_vec` is 0.
- R2: `src_req` bit 0 is program, bit 1 is I/O, bit 2 is timer and bit 3 is hardware failure. Priority rises with the bit number. When `irq_req` is 1, `irq_vec` is the number of the highest-priority source that is both pending and allowed. When `irq_req` is 0, `irq_vec` is 0.
- R3: A request held for one cycle stays pending until it is acknowledged. After the edge that samples it, `irq_req` stays high for any number of cycles.
- R4: `irq_ack` sampled while `irq_req` is 1 clears the pending bit of the presented source and marks that source in service. Both effects show after that edge.
- R5: `irq_ack` sampled while `irq_req` is 0 changes nothing.
- R6: With `nest_en`=0, `irq_req` is 0 while any source is in service. Requests that arrive meanwhile stay pending and are offered once no service is active.
- R7: With `nest_en`=1 and a service active, only pending sources of strictly higher priority than the highest active service are offered. Sources of equal or lower priority stay pending.
- R8: `eoi` retires only the highest-priority active service. Lower active services remain active and keep blocking lower and equal requests.
- R9: `eoi` with no service active changes nothing.
- R10: A new request from a source arriving in the same cycle as that source's acknowledge leaves it pending and also in service.
- R11: A change of `nest_en` alters `irq_req` and `irq_vec` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 4 | Request per source class, sampled on every edge |
| nest_en | input | 1 | 0: hold all while servicing; 1: strictly-higher preemption |
| irq_ack | input | 1 | Processor takes the presented source |
| eoi | input | 1 | Processor finished its current (top) service |
| irq_req | output | 1 | A pending source is allowed now |
| irq_vec | output | 2 | Number of the offered source |

## Verification
The bench builds the block with its default of four sources. This value covers the whole priority order and stacks of up to four nested services. With it, the bench can drive all four sources at once and drain them in order, and it can push a hardware-failure service on top of an active I/O service. It can then show that the I/O service still holds back lower and equal requests after the top service retires. The same value also reaches the same-cycle collision of acknowledge and request, and a mode flip in the middle of a service.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  // Source numbering: priority rises with the number.
  typedef enum logic [1:0] {
    SRC_PROG = 2'd0,
    SRC_IO   = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_HWF  = 2'd3
  } src_id_e;

  typedef enum logic {
    POL_HOLD_ALL = 1'b0,
    POL_PREEMPT  = 1'b1
  } policy_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NSRC-1:0]  pend
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic            pend_upd;

  assign pend_upd = (|req) | clr_en;

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    logic hit_clr;
    assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

    // A fresh request wins over a clear in the same cycle.
    always_comb begin
      pend_d[g] = (pend_q[g] & ~hit_clr) | req[g];
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !hit_clr) |=> pend_q[g]); // R3
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_upd) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             eoi,
  output logic             top_valid,
  output logic [IDX_W-1:0] top_idx
);
  logic [NSRC-1:0] isr_q;
  logic [NSRC-1:0] isr_d;
  logic [NSRC-1:0] pop_mask;
  logic [NSRC-1:0] push_mask;
  logic            isr_upd;

  // Highest active service is the top of the stack.
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (isr_q[i]) top_idx = IDX_W'(i);
    end
  end

  assign top_valid = |isr_q;

  always_comb begin
    pop_mask  = '0;
    push_mask = '0;
    if (eoi && top_valid) pop_mask[top_idx] = 1'b1;
    if (set_en)           push_mask[set_idx] = 1'b1;
    isr_d = (isr_q & ~pop_mask) | push_mask;
  end

  assign isr_upd = set_en | eoi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else if (isr_upd) begin
      isr_q <= isr_d;
    end
  end

  AST_ISR_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> isr_q[$past(set_idx)]); // R4

  AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !set_en && top_valid) |=>
      (($countones(isr_q) + 1) == $countones($past(isr_q)))); // R8

  AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !set_en && !top_valid) |=> !top_valid); // R9
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  pend,
  input  logic             top_valid,
  input  logic [IDX_W-1:0] top_idx,
  input  logic             nest_en,
  output logic             req,
  output logic [IDX_W-1:0] vec
);
  logic [NSRC-1:0] allow;
  logic [NSRC-1:0] cand;

  for (genvar g = 0; g < NSRC; g++) begin : g_allow
    assign allow[g] = !top_valid || (nest_en && (IDX_W'(g) > top_idx));
  end

  assign cand = pend & allow;
  assign req  = |cand;

  always_comb begin
    vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i]) vec = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic             nest_en,
  input  logic             irq_ack,
  input  logic             eoi,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_vec
);
  import irq_nest_pkg::*;

  logic [NSRC-1:0]  pend;
  logic             take;
  logic             top_valid;
  logic [IDX_W-1:0] top_idx;
  policy_e          policy;

  assign policy = policy_e'(nest_en);
  assign take   = irq_ack & irq_req;

  irq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (src_req),
    .clr_en  (take),
    .clr_idx (irq_vec),
    .pend    (pend)
  );

  irq_isr_track #(.NSRC(NSRC)) u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (take),
    .set_idx   (irq_vec),
    .eoi       (eoi),
    .top_valid (top_valid),
    .top_idx   (top_idx)
  );

  irq_prio_sel #(.NSRC(NSRC)) u_sel (
    .pend      (pend),
    .top_valid (top_valid),
    .top_idx   (top_idx),
    .nest_en   (policy == POL_PREEMPT),
    .req       (irq_req),
    .vec       (irq_vec)
  );

  AST_VEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend[irq_vec]); // R2

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == '0)); // R2

  AST_HOLD_ALL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && top_valid) |-> !irq_req); // R6

  AST_PREEMPT_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_en && top_valid && irq_req) |-> (irq_vec > top_idx)); // R7

  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !eoi && (src_req == '0)) |=> $stable(pend)); // R5
endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic [3:0] src_req;
  logic       nest_en;
  logic       irq_ack;
  logic       eoi;
  logic       irq_req;
  logic [1:0] irq_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  irq_nest_ctrl #(.NSRC(4)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_req (src_req),
    .nest_en (nest_en),
    .irq_ack (irq_ack),
    .eoi     (eoi),
    .irq_req (irq_req),
    .irq_vec (irq_vec)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(string tag, int req_e, int vec_e);
    check({tag, " req"}, int'(irq_req), req_e);
    check({tag, " vec"}, int'(irq_vec), vec_e);
  endtask

  task automatic pulse_req(logic [3:0] m);
    src_req = m;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 0, 0);
  endtask

  task automatic t_sticky();
    nest_en = 1'b0;
    pulse_req(4'b0100);
    expect_out("R3 timer latched", 1, 2);
    repeat (6) @(negedge clk);
    expect_out("R3 still pending", 1, 2);
    do_ack();
    expect_out("R4 ack clears pending", 0, 0);
    do_eoi();
    expect_out("R4 idle after eoi", 0, 0);
  endtask

  task automatic t_priority();
    nest_en = 1'b0;
    pulse_req(4'b1111);
    expect_out("R2 hw failure first", 1, 3);
    do_ack();
    expect_out("R6 held during service", 0, 0);
    do_eoi();
    expect_out("R2 timer next", 1, 2);
    do_ack(); do_eoi();
    expect_out("R2 io next", 1, 1);
    do_ack(); do_eoi();
    expect_out("R2 program last", 1, 0);
    do_ack(); do_eoi();
    expect_out("R2 drained", 0, 0);
  endtask

  task automatic t_ack_ignored();
    nest_en = 1'b0;
    do_ack();
    expect_out("R5 stray ack", 0, 0);
    pulse_req(4'b0001);
    expect_out("R5 no phantom service", 1, 0);
    do_ack(); do_eoi();
    expect_out("R5 clean", 0, 0);
  endtask

  task automatic t_hold_all();
    nest_en = 1'b0;
    pulse_req(4'b0001);
    do_ack();
    pulse_req(4'b1000);
    expect_out("R6 higher held", 0, 0);
    repeat (3) @(negedge clk);
    expect_out("R6 still held", 0, 0);
    do_eoi();
    expect_out("R6 offered after eoi", 1, 3);
    do_ack(); do_eoi();
    expect_out("R6 clean", 0, 0);
  endtask

  task automatic t_nesting();
    nest_en = 1'b1;
    pulse_req(4'b0010);
    do_ack();
    pulse_req(4'b0001);
    expect_out("R7 lower held", 0, 0);
    pulse_req(4'b0010);
    expect_out("R7 equal held", 0, 0);
    pulse_req(4'b1000);
    expect_out("R7 higher preempts", 1, 3);
    do_ack();
    expect_out("R7 nothing above hwf", 0, 0);
    pulse_req(4'b0100);
    expect_out("R7 timer below hwf", 0, 0);
    do_eoi();
    expect_out("R8 io still active, timer offered", 1, 2);
    do_ack();
    expect_out("R8 timer in service", 0, 0);
    do_eoi();
    expect_out("R8 io resumed blocks io and program", 0, 0);
    do_eoi();
    expect_out("R8 io offered after io done", 1, 1);
    do_ack(); do_eoi();
    expect_out("R8 program last", 1, 0);
    do_ack(); do_eoi();
    expect_out("R8 clean", 0, 0);
  endtask

  task automatic t_eoi_idle();
    nest_en = 1'b0;
    do_eoi();
    expect_out("R9 eoi idle", 0, 0);
    pulse_req(4'b0010);
    do_ack();
    pulse_req(4'b0001);
    expect_out("R9 service still held", 0, 0);
    do_eoi();
    expect_out("R9 program offered", 1, 0);
    do_ack(); do_eoi();
    expect_out("R9 clean", 0, 0);
  endtask

  task automatic t_ack_collide();
    nest_en = 1'b1;
    pulse_req(4'b0100);
    src_req = 4'b0100;
    irq_ack = 1'b1;
    @(negedge clk);
    src_req = '0;
    irq_ack = 1'b0;
    expect_out("R10 equal pending blocked", 0, 0);
    do_eoi();
    expect_out("R10 repeat request kept", 1, 2);
    do_ack(); do_eoi();
    expect_out("R10 clean", 0, 0);
  endtask

  task automatic t_mode_flip();
    nest_en = 1'b0;
    pulse_req(4'b0001);
    do_ack();
    pulse_req(4'b0100);
    expect_out("R11 held in hold mode", 0, 0);
    nest_en = 1'b1;
    #1;
    expect_out("R11 offered on flip", 1, 2);
    nest_en = 1'b0;
    #1;
    expect_out("R11 held on flip back", 0, 0);
    @(negedge clk);
    do_eoi();
    expect_out("R11 offered after eoi", 1, 2);
    do_ack(); do_eoi();
    expect_out("R11 clean", 0, 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    src_req = '0;
    nest_en = 1'b0;
    irq_ack = 1'b0;
    eoi     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_priority();
    t_ack_ignored();
    t_hold_all();
    t_nesting();
    t_eoi_idle();
    t_ack_collide();
    t_mode_flip();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule